// File: doc/BRIEF.md
# Dual-channel UART host bus front end

This block sits between a host processor bus and the two serial channels of a dual UART. The host drives an 8-bit data bus, three address lines, an active-low chip select, active-low read and write strobes and a channel select. The strobes are asynchronous. The block brings them into its system clock domain, decodes the access, and routes it to channel A or channel B. Each channel keeps a line control register, a 16-bit divisor held as a low and a high byte, and an alternate-function register. Every other offset is passed to the channel's serial engines through a simple per-channel register port.

A channel whose two divisor bytes are both zero returns fixed identification and revision codes when the divisor bytes are read. The stored values are not changed by this. Each channel also drives a multifunction output pin. Its alternate-function register selects the source: receive-ready, the OP2 output or the baud clock, all active low, or a constant inactive high level.

An active-high device reset clears both channels. It is filtered, so a pulse shorter than a programmable number of system clocks is ignored.

Top module: `dual_uart_hostif`

## Requirements
- R1: After an accepted reset, every local register of both channels reads 0x00: line control, both divisor bytes and alternate function. Because the divisor is then zero, the identification readback is active.
- R2: `dev_reset` takes effect only after it has been high for `RST_HOLD` consecutive system clocks (default 4). A high pulse of `RST_HOLD`-1 clocks leaves all register contents unchanged.
- R3: Offset 3 is the line control register. While its bit 7 is 1, the local registers are placed as follows:
  - offset 0: divisor low byte
  - offset 1: divisor high byte
  - offset 2: alternate-function register

  Every other access goes to the external port. A write pulses `ext_we` for the selected channel with `ext_addr`/`ext_wdata`. A read pulses `ext_re` once and returns that channel's `ext_rdata_*` byte.
- R4: With `chsel`=0 an access reaches channel A (index 0); with `chsel`=1 it reaches channel B (index 1). A write to one channel leaves the other channel's registers unchanged.
- R5: While a channel's divisor low and high bytes are both 0x00, reading offset 1 with bit 7 of line control set returns `ID_CODE` (default 0x0A), and reading offset 0 returns `REV_CODE` (default 0x01).
- R6: Writes to the divisor bytes always store the written value, including while the identification readback is active. Once either byte is nonzero, reads return the stored bytes, and `div_a`/`div_b` always show {high, low}.
- R7: A write is committed only after the write strobe is released. While `iow_n` stays low, the target register keeps its old value.
- R8: While chip select and the read strobe are held low, `dout_en` is 1 and `dout` holds the read data. When no read is in progress, `dout_en` is 0 and `dout` is 0x00. A strobe given while `cs_n` is high has no effect.
- R9: The alternate-function register bits [2:1] select what drives `mf_n` of that channel: 00 gives ~`op2`, 01 gives ~`baud_clk`, 10 gives ~`rx_rdy`, and 11 drives a constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| dev_reset | input | 1 | Active-high device reset, filtered |
| cs_n | input | 1 | Chip select, active low |
| ior_n | input | 1 | Read strobe, active low, asynchronous |
| iow_n | input | 1 | Write strobe, active low, asynchronous |
| chsel | input | 1 | Channel select: 0 = A, 1 = B |
| addr | input | 3 | Register offset |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_en | output | 1 | Read data valid / bus drive enable |
| ext_addr | output | 3 | Offset for external register access |
| ext_wdata | output | 8 | Write data for external register access |
| ext_we | output | 2 | External write pulse per channel |
| ext_re | output | 2 | External read pulse per channel |
| ext_rdata_a | input | 8 | External read data, channel A |
| ext_rdata_b | input | 8 | External read data, channel B |
| rx_rdy | input | 2 | Receive-ready per channel, active high |
| op2 | input | 2 | OP2 output level per channel, active high |
| baud_clk | input | 2 | Baud clock per channel |
| mf_n | output | 2 | Multifunction pin per channel |
| div_a | output | 16 | Channel A divisor {high, low} |
| div_b | output | 16 | Channel B divisor {high, low} |

## Verification
The hardest cases to reach are the reset width boundary and the readback override.

For the reset, the bench first programs nonzero values into the registers. It then gives a reset pulse exactly one clock short of the threshold and reads the registers back. After that it gives a pulse long enough to be accepted.

For the override, the bench writes a nonzero divisor byte and then zeroes it again through the bus. Identification readback must come back while `div_a`/`div_b` still show the true stored values.

Random accesses with mixed channels and offsets run against a reference model in the bench, so channel isolation is checked after every write.

// File: rtl/dual_uart_pkg.sv
// Shared constants and types of the dual UART host front end.
package dual_uart_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NCHAN  = 2;

    localparam logic [ADDR_W-1:0] OFS_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ALT    = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LINE   = 3'd3;

    typedef enum logic [1:0] {
        MF_OP2   = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_IDLE  = 2'b11
    } mf_sel_e;

    // True when the offset maps to a register held in this block.
    function automatic logic is_local(input logic [ADDR_W-1:0] a, input logic div_access);
        return (a == OFS_LINE) ||
               (div_access && (a == OFS_DIV_LO || a == OFS_DIV_HI || a == OFS_ALT));
    endfunction
endpackage

// File: rtl/rst_filter.sv
// Reset width filter.
// Drives rst_n low once rst_req has been high for HOLD consecutive clocks.
// rst_n stays low while rst_req stays high.
// Assumes HOLD >= 1. The filter itself needs no reset: its counter clears
// whenever rst_req is low.
module rst_filter #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_req,
    output logic rst_n
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;

    // Count consecutive high clocks of the reset request, saturating at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_req)
            cnt <= '0;
        else if (cnt != CW'(HOLD))
            cnt <= cnt + 1'b1;
    end

    // Issue the internal reset once the count has saturated.
    always_ff @(posedge clk) begin
        rst_n <= !(cnt == CW'(HOLD));
    end

    // R2: internal reset only starts after the request was high.
    a_r2_reset_needs_request: assert property (@(posedge clk)
        $fell(rst_n) |-> $past(rst_req));
endmodule

// File: rtl/strobe_sync.sv
// Multi-flop synchronizer for an asynchronous level.
// Gives the synchronized level plus single-cycle rise and fall pulses.
// Assumes STAGES >= 2.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    // Shift the asynchronous level through the synchronizer chain and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else
            sh <= {sh[STAGES-1:0], async_in};
    end

    assign level = sh[STAGES-1];
    assign rise  = sh[STAGES-1] & ~sh[STAGES];
    assign fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/chan_regs.sv
// Register set of one UART channel: line control, divisor bytes and
// alternate-function register.
// Also returns the identification/revision override and drives the
// multifunction pin mux.
// Assumes wr_en is a single-cycle commit pulse, with wr_addr/wr_data stable
// in that cycle.
module chan_regs
    import dual_uart_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_CODE  = 8'h0A,
    parameter logic [DATA_W-1:0] REV_CODE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_local,
    output logic              ext_we,
    input  logic              rx_rdy,
    input  logic              op2,
    input  logic              baud_clk,
    output logic              mf_n,
    output logic [2*DATA_W-1:0] divisor
);
    logic [DATA_W-1:0] line_q, dlo_q, dhi_q, alt_q;
    logic              div_acc, div_zero, wr_local;
    mf_sel_e           mf_sel;

    assign div_acc  = line_q[7];
    assign div_zero = (dlo_q == '0) && (dhi_q == '0);
    assign wr_local = is_local(wr_addr, div_acc);
    assign rd_local = is_local(rd_addr, div_acc);
    assign ext_we   = wr_en && !wr_local;
    assign divisor  = {dhi_q, dlo_q};
    assign mf_sel   = mf_sel_e'(alt_q[2:1]);

    // Commit host writes to the local registers of this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
            alt_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == OFS_LINE)
                line_q <= wr_data;
            else if (div_acc && wr_addr == OFS_DIV_LO)
                dlo_q <= wr_data;
            else if (div_acc && wr_addr == OFS_DIV_HI)
                dhi_q <= wr_data;
            else if (div_acc && wr_addr == OFS_ALT)
                alt_q <= wr_data;
        end
    end

    // Select read data, replacing the divisor bytes with codes when the divisor is zero.
    always_comb begin
        rd_data = ext_rdata;
        if (rd_addr == OFS_LINE)
            rd_data = line_q;
        else if (div_acc && rd_addr == OFS_DIV_LO)
            rd_data = div_zero ? REV_CODE : dlo_q;
        else if (div_acc && rd_addr == OFS_DIV_HI)
            rd_data = div_zero ? ID_CODE : dhi_q;
        else if (div_acc && rd_addr == OFS_ALT)
            rd_data = alt_q;
    end

    // Route the chosen active-low source to the multifunction pin.
    always_comb begin
        unique case (mf_sel)
            MF_OP2:   mf_n = ~op2;
            MF_BAUD:  mf_n = ~baud_clk;
            MF_RXRDY: mf_n = ~rx_rdy;
            default:  mf_n = 1'b1;
        endcase
    end

    // R4: without a commit pulse the channel registers keep their value.
    a_r4_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(line_q));
    a_r4_alt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(alt_q));
    // R6: the stored divisor only changes on a commit.
    a_r6_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(divisor));
    // R5: a zero divisor reads back as the identification code.
    a_r5_id_code: assert property (@(posedge clk) disable iff (!rst_n)
        (div_acc && rd_addr == OFS_DIV_HI && divisor == '0) |-> rd_data == ID_CODE);
    // R9: the idle selection keeps the pin inactive.
    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_q[2:1] == 2'b11) |-> mf_n);
endmodule

// File: rtl/dual_uart_hostif.sv
// Host bus front end of a dual UART.
// Synchronizes the asynchronous read/write strobes and commits writes on
// strobe release. It captures read data on read start and holds it, and
// steers accesses to channel A or B.
// Assumes addr, din and chsel are stable while their strobe is low, and for
// a read until dout is sampled.
module dual_uart_hostif
    import dual_uart_pkg::*;
#(
    parameter int                RST_HOLD    = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ID_CODE     = 8'h0A,
    parameter logic [DATA_W-1:0] REV_CODE    = 8'h01
) (
    input  logic                clk,
    input  logic                dev_reset,
    input  logic                cs_n,
    input  logic                ior_n,
    input  logic                iow_n,
    input  logic                chsel,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic                dout_en,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [DATA_W-1:0]   ext_wdata,
    output logic [NCHAN-1:0]    ext_we,
    output logic [NCHAN-1:0]    ext_re,
    input  logic [DATA_W-1:0]   ext_rdata_a,
    input  logic [DATA_W-1:0]   ext_rdata_b,
    input  logic [NCHAN-1:0]    rx_rdy,
    input  logic [NCHAN-1:0]    op2,
    input  logic [NCHAN-1:0]    baud_clk,
    output logic [NCHAN-1:0]    mf_n,
    output logic [2*DATA_W-1:0] div_a,
    output logic [2*DATA_W-1:0] div_b
);
    logic rst_n;
    logic rd_lvl, rd_rise, rd_fall_unused;
    logic wr_lvl, wr_rise_unused, wr_commit;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;
    logic              wr_ch_q;
    logic [DATA_W-1:0] rd_hold_q;
    logic              dout_en_q;

    logic [DATA_W-1:0]   ch_rdata [NCHAN];
    logic [DATA_W-1:0]   ch_ext_rd [NCHAN];
    logic [2*DATA_W-1:0] ch_div [NCHAN];
    logic [NCHAN-1:0]    ch_wr_en, ch_rd_local;

    assign ch_ext_rd[0] = ext_rdata_a;
    assign ch_ext_rd[1] = ext_rdata_b;
    assign div_a = ch_div[0];
    assign div_b = ch_div[1];

    rst_filter #(.HOLD(RST_HOLD)) u_rst (
        .clk(clk), .rst_req(dev_reset), .rst_n(rst_n)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(~cs_n & ~ior_n),
        .level(rd_lvl), .rise(rd_rise), .fall(rd_fall_unused)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .async_in(~cs_n & ~iow_n),
        .level(wr_lvl), .rise(wr_rise_unused), .fall(wr_commit)
    );

    // Latch the write target while the synchronized write strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_data_q <= '0;
            wr_ch_q   <= 1'b0;
        end else if (wr_lvl) begin
            wr_addr_q <= addr;
            wr_data_q <= din;
            wr_ch_q   <= chsel;
        end
    end

    // Capture read data at read start and drive it until the read strobe is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hold_q <= '0;
            dout_en_q <= 1'b0;
        end else begin
            if (rd_rise)
                rd_hold_q <= ch_rdata[chsel];
            dout_en_q <= rd_lvl;
        end
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic ext_we_c;
        assign ch_wr_en[c] = wr_commit && (wr_ch_q == 1'(c));
        assign ext_we[c]   = ext_we_c;
        assign ext_re[c]   = rd_rise && (chsel == 1'(c)) && !ch_rd_local[c];

        chan_regs #(.ID_CODE(ID_CODE), .REV_CODE(REV_CODE)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .wr_en(ch_wr_en[c]), .wr_addr(wr_addr_q), .wr_data(wr_data_q),
            .rd_addr(addr), .ext_rdata(ch_ext_rd[c]),
            .rd_data(ch_rdata[c]), .rd_local(ch_rd_local[c]), .ext_we(ext_we_c),
            .rx_rdy(rx_rdy[c]), .op2(op2[c]), .baud_clk(baud_clk[c]),
            .mf_n(mf_n[c]), .divisor(ch_div[c])
        );
    end

    assign ext_addr  = wr_commit ? wr_addr_q : addr;
    assign ext_wdata = wr_data_q;
    assign dout_en   = dout_en_q;
    assign dout      = dout_en_q ? rd_hold_q : '0;

    // R7: a write commit is a single-cycle pulse.
    a_r7_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
    // R4: an access never reaches both channels at once.
    a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr_en) && $onehot0(ext_re));
    // R8: no bus drive once the read has been idle for a cycle.
    a_r8_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lvl && $past(!rd_lvl)) |-> !dout_en);
endmodule

// File: tb/dual_uart_hostif_tb.sv
module dual_uart_hostif_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;
    localparam logic [7:0] EXT_A = 8'h5A;
    localparam logic [7:0] EXT_B = 8'hC3;

    logic clk = 1'b0;
    logic dev_reset = 1'b0;
    logic cs_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1, chsel = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en;
    logic [2:0] ext_addr;
    logic [7:0] ext_wdata;
    logic [1:0] ext_we, ext_re;
    logic [1:0] rx_rdy = '0, op2 = '0, baud_clk = '0;
    logic [1:0] mf_n;
    logic [15:0] div_a, div_b;

    int n_checks = 0;
    int n_fail = 0;
    int we_cnt [2];
    int re_cnt [2];
    logic [7:0] m_line [2], m_dlo [2], m_dhi [2], m_alt [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_uart_hostif #(.RST_HOLD(HOLD)) u_dut (
        .clk(clk), .dev_reset(dev_reset), .cs_n(cs_n), .ior_n(ior_n), .iow_n(iow_n),
        .chsel(chsel), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_we(ext_we), .ext_re(ext_re),
        .ext_rdata_a(EXT_A), .ext_rdata_b(EXT_B),
        .rx_rdy(rx_rdy), .op2(op2), .baud_clk(baud_clk), .mf_n(mf_n),
        .div_a(div_a), .div_b(div_b)
    );

    // Count external access pulses per channel.
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (ext_we[c]) we_cnt[c] = we_cnt[c] + 1;
            if (ext_re[c]) re_cnt[c] = re_cnt[c] + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int c, input logic [2:0] a);
        logic dz;
        dz = (m_dlo[c] == 8'h00) && (m_dhi[c] == 8'h00);
        if (a == 3'd3) return m_line[c];
        if (m_line[c][7] && a == 3'd0) return dz ? 8'h01 : m_dlo[c];
        if (m_line[c][7] && a == 3'd1) return dz ? 8'h0A : m_dhi[c];
        if (m_line[c][7] && a == 3'd2) return m_alt[c];
        return (c == 0) ? EXT_A : EXT_B;
    endfunction

    function automatic bit is_ext(input int c, input logic [2:0] a);
        return !(a == 3'd3 || (m_line[c][7] && a <= 3'd2));
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_line[c] = 8'h00; m_dlo[c] = 8'h00; m_dhi[c] = 8'h00; m_alt[c] = 8'h00;
        end
    endtask

    task automatic model_write(input int c, input logic [2:0] a, input logic [7:0] d);
        if (a == 3'd3) m_line[c] = d;
        else if (m_line[c][7] && a == 3'd0) m_dlo[c] = d;
        else if (m_line[c][7] && a == 3'd1) m_dhi[c] = d;
        else if (m_line[c][7] && a == 3'd2) m_alt[c] = d;
    endtask

    task automatic bus_write(input int c, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        chsel = 1'(c); addr = a; din = d; cs_n = 1'b0; iow_n = 1'b0;
        repeat (4) @(negedge clk);
        iow_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        model_write(c, a, d);
    endtask

    task automatic bus_read(input int c, input logic [2:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        chsel = 1'(c); addr = a; cs_n = 1'b0; ior_n = 1'b0;
        repeat (5) @(negedge clk);
        d = dout; en = dout_en;
        ior_n = 1'b1; cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_check(input string req, input int c, input logic [2:0] a);
        logic [7:0] d; logic en; int re0;
        bit ext;
        ext = is_ext(c, a);
        re0 = re_cnt[c];
        bus_read(c, a, d, en);
        check(req, {24'd0, d}, {24'd0, exp_read(c, a)});
        check("R8 dout_en during read", {31'd0, en}, 32'd1);
        check("R3 ext_re pulse count", re_cnt[c] - re0, ext ? 1 : 0);
    endtask

    task automatic check_divs(input string req);
        check(req, {16'd0, div_a}, {16'd0, m_dhi[0], m_dlo[0]});
        check(req, {16'd0, div_b}, {16'd0, m_dhi[1], m_dlo[1]});
    endtask

    task automatic pulse_reset(input int n);
        @(negedge clk);
        dev_reset = 1'b1;
        repeat (n) @(negedge clk);
        dev_reset = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d; logic en;
        int w0;
        void'($urandom(32'h2752));
        we_cnt[0] = 0; we_cnt[1] = 0; re_cnt[0] = 0; re_cnt[1] = 0;
        model_reset();
        repeat (2) @(negedge clk);
        pulse_reset(HOLD + 4);

        // R1: defaults after reset
        check("R8 idle dout_en", {31'd0, dout_en}, 32'd0);
        check("R8 idle dout", {24'd0, dout}, 32'd0);
        check_divs("R1 divisor after reset");
        for (int c = 0; c < 2; c++) begin
            read_check("R1 line ctrl default", c, 3'd3);
            bus_write(c, 3'd3, 8'h80);
            read_check("R1 R5 rev code at zero divisor", c, 3'd0);
            read_check("R1 R5 id code at zero divisor", c, 3'd1);
            read_check("R1 alt default", c, 3'd2);
        end

        // R6: stored value wins once nonzero; zero again restores override
        bus_write(0, 3'd0, 8'h12);
        read_check("R6 stored low byte", 0, 3'd0);
        read_check("R6 stored high byte zero", 0, 3'd1);
        check_divs("R6 divisor port");
        bus_write(0, 3'd0, 8'h00);
        read_check("R5 R6 rev after re-zero", 0, 3'd0);
        read_check("R5 R6 id after re-zero", 0, 3'd1);
        check_divs("R6 divisor port zero");

        // R4: isolation of channel B during channel A writes
        bus_write(0, 3'd1, 8'h34);
        read_check("R4 channel B high unaffected", 1, 3'd1);
        check_divs("R4 divisor isolation");

        // R7: commit only after strobe release
        @(negedge clk);
        chsel = 1'b0; addr = 3'd0; din = 8'h77; cs_n = 1'b0; iow_n = 1'b0;
        repeat (12) @(negedge clk);
        check("R7 no update while strobe held", {16'd0, div_a}, {16'd0, m_dhi[0], m_dlo[0]});
        iow_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        model_write(0, 3'd0, 8'h77);
        check("R7 update after release", {16'd0, div_a}, 32'h00003477);

        // R8: strobe with cs high ignored
        @(negedge clk);
        chsel = 1'b0; addr = 3'd3; din = 8'h1F; cs_n = 1'b1; iow_n = 1'b0;
        repeat (5) @(negedge clk);
        iow_n = 1'b1;
        repeat (5) @(negedge clk);
        read_check("R8 write with cs high ignored", 0, 3'd3);
        @(negedge clk);
        addr = 3'd3; cs_n = 1'b1; ior_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 read with cs high no drive", {31'd0, dout_en}, 32'd0);
        ior_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: external access path
        w0 = we_cnt[1];
        bus_write(1, 3'd5, 8'hE4);
        check("R3 ext_we pulse", we_cnt[1] - w0, 1);
        check("R3 ext_wdata", {24'd0, ext_wdata}, 32'h000000E4);
        read_check("R3 ext read channel B", 1, 3'd6);
        bus_write(1, 3'd3, 8'h03);
        w0 = we_cnt[1];
        bus_write(1, 3'd0, 8'h99);
        check("R3 offset0 external with bit7 clear", we_cnt[1] - w0, 1);
        read_check("R3 offset0 reads ext", 1, 3'd0);
        check_divs("R3 divisor untouched");

        // R9: multifunction mux on channel A
        bus_write(0, 3'd2, 8'h04);
        rx_rdy = 2'b01; #1;
        check("R9 rxrdy sel low", {31'd0, mf_n[0]}, 32'd0);
        rx_rdy = 2'b00; #1;
        check("R9 rxrdy sel high", {31'd0, mf_n[0]}, 32'd1);
        bus_write(0, 3'd2, 8'h00);
        op2 = 2'b01; #1;
        check("R9 op2 sel", {31'd0, mf_n[0]}, 32'd0);
        op2 = 2'b00;
        bus_write(0, 3'd2, 8'h02);
        baud_clk = 2'b01; #1;
        check("R9 baud sel low", {31'd0, mf_n[0]}, 32'd0);
        baud_clk = 2'b00; #1;
        check("R9 baud sel high", {31'd0, mf_n[0]}, 32'd1);
        bus_write(0, 3'd2, 8'h06);
        rx_rdy = 2'b11; op2 = 2'b11; baud_clk = 2'b11; #1;
        check("R9 idle sel", {31'd0, mf_n[0]}, 32'd1);
        check("R9 channel B op2 default", {31'd0, mf_n[1]}, 32'd0);
        rx_rdy = 2'b00; op2 = 2'b00; baud_clk = 2'b00;

        // R2: short reset pulse ignored, full pulse accepted
        pulse_reset(HOLD - 1);
        read_check("R2 short pulse keeps line ctrl", 0, 3'd3);
        read_check("R2 short pulse keeps alt", 0, 3'd2);
        check_divs("R2 short pulse keeps divisor");
        pulse_reset(HOLD + 2);
        model_reset();
        check_divs("R1 R2 divisor cleared");
        read_check("R1 R2 line ctrl cleared", 0, 3'd3);

        // Random mix against the reference model
        for (int i = 0; i < 400; i++) begin
            int c; logic [2:0] a; logic [7:0] v;
            c = int'($urandom % 2);
            a = 3'($urandom % 8);
            v = 8'($urandom);
            if (a == 3'd3 && ($urandom % 2) == 0) v[7] = 1'b1;
            if (a <= 3'd1 && ($urandom % 3) == 0) v = 8'h00;
            if ($urandom % 2 == 0) begin
                bus_write(c, a, v);
                check_divs("R4 R6 random divisor");
            end else begin
                read_check("R3 R5 random read", c, a);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule